// File: doc/BRIEF.md
# Synchronous Serial Character Receiver

This block takes in serial characters on one data line that is sampled once for each pulse of a baud-rate enable. No oversampling is done. While the receiver is idle, a low level seen on an enable pulse counts as the start bit. The enable pulses after that shift in the data bits, least significant bit first. A parity bit follows if a configuration input turns parity on, and then one stop bit. When a character is finished it is copied into a holding register and a ready flag rises.

The bus side reads the holding register with a read strobe, and that read drops the ready flag. If a new character finishes while the ready flag is still up, the new character overwrites the old one and a sticky overrun flag is set. Parity and stop-bit errors each set their own sticky flag. The three sticky flags clear only when a control write carries its reset-status bit.

Top module: `sync_serial_rx`

## Requirements
- R1: After reset `rx_ready`, `ovr_err`, `par_err` and `frm_err` are 0 and `hold_data` is 0.
- R2: While idle, a 0 on `rxd` sampled on a `baud_en` cycle is the start bit. The next DATA_W enabled samples are data bits, and the first of them goes to bit 0. An optional parity sample comes next, then the stop sample. Two clock edges after the edge that samples the stop bit, `hold_data` shows the character and `rx_ready` is 1.
- R3: `rxd` is ignored on cycles when `baud_en` is 0, so each bit is sampled once per enable pulse.
- R4: A pulse on `rd_hold` with no character completing in the same cycle clears `rx_ready` at the next edge and leaves `hold_data` unchanged.
- R5: If a character completes while `rx_ready` is 1 and `rd_hold` is 0, `ovr_err` becomes 1 and `hold_data` takes the new character.
- R6: `ovr_err` stays set through reads, and through control writes that have `ctl_rst_stat` at 0.
- R7: `par_mode` selects the parity: 0 = no parity bit, 1 = even, 2 = odd, 3 = no parity bit. With even parity the data bits plus the parity bit hold an even number of ones, and with odd parity an odd number. A mismatch sets the sticky `par_err`.
- R8: A 0 sampled in the stop-bit position sets the sticky `frm_err`. The character is still loaded and `rx_ready` is still set.
- R9: If `rd_hold` and a character completion fall in the same cycle, the completion wins: `rx_ready` stays 1, the new character is loaded and `ovr_err` is not set.
- R10: A cycle with `ctl_wr` = 1 and `ctl_rst_stat` = 1 clears `ovr_err`, `par_err` and `frm_err` together at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_en | input | 1 | Baud-rate sample enable, one cycle per bit |
| rxd | input | 1 | Serial data line |
| par_mode | input | 2 | Parity selection (0 none, 1 even, 2 odd, 3 none) |
| rd_hold | input | 1 | Holding-register read strobe |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rst_stat | input | 1 | Reset-status command bit of the control write |
| hold_data | output | DATA_W | Receive holding register |
| rx_ready | output | 1 | Character available |
| ovr_err | output | 1 | Sticky overrun flag |
| par_err | output | 1 | Sticky parity-error flag |
| frm_err | output | 1 | Sticky framing-error flag |

## Verification
If the bit counter or the frame state is off by one, the next character shows up at `hold_data` shifted or misaligned, and `frm_err` or `par_err` may be set wrongly. Either appears two edges after the stop sample. A ready flag in the wrong state shows up at the next completion: `ovr_err` is set when it should not be, or stays clear when it should be set. The coincident read and completion case, and the control writes that must not clear anything, are driven on exact cycles so that a wrong priority shows on the very next edge.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } rx_state_e;

    localparam logic [1:0] PAR_NONE = 2'd0;
    localparam logic [1:0] PAR_EVEN = 2'd1;
    localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import sync_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_en,
    input  logic              rxd,
    input  logic [1:0]        par_mode,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              par_bad_o,
    output logic              frm_bad_o
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sr;
        logic              acc;
        logic              par_bad;
        logic              frm_bad;
        logic              done;
        logic [DATA_W-1:0] data_out;
    } fsm_t;

    fsm_t r_q, r_d;
    logic par_on;

    assign par_on = (par_mode == PAR_EVEN) || (par_mode == PAR_ODD);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (baud_en) begin
            case (r_q.state)
                ST_IDLE: begin
                    if (!rxd) begin
                        r_d.state   = ST_DATA;
                        r_d.cnt     = '0;
                        r_d.acc     = 1'b0;
                        r_d.par_bad = 1'b0;
                    end
                end
                ST_DATA: begin
                    r_d.sr  = {rxd, r_q.sr[DATA_W-1:1]};
                    r_d.acc = r_q.acc ^ rxd;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.state = par_on ? ST_PAR : ST_STOP;
                    end
                end
                ST_PAR: begin
                    r_d.par_bad = rxd != (r_q.acc ^ (par_mode == PAR_ODD));
                    r_d.state   = ST_STOP;
                end
                default: begin
                    r_d.done     = 1'b1;
                    r_d.frm_bad  = !rxd;
                    r_d.data_out = r_q.sr;
                    r_d.state    = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign done_o    = r_q.done;
    assign data_o    = r_q.data_out;
    assign par_bad_o = r_q.par_bad;
    assign frm_bad_o = r_q.frm_bad;

    AST_NO_STEP_WITHOUT_BAUD: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_en |=> $stable(r_q.state) && $stable(r_q.sr)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
endmodule

// File: rtl/rx_hold_status.sv
module rx_hold_status #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              par_bad_i,
    input  logic              frm_bad_i,
    input  logic              rd_i,
    input  logic              ctl_wr_i,
    input  logic              ctl_rst_stat_i,
    output logic [DATA_W-1:0] hold_o,
    output logic              ready_o,
    output logic              ovr_o,
    output logic              perr_o,
    output logic              ferr_o
);
    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic              ready;
        logic              ovr;
        logic              perr;
        logic              ferr;
    } stat_t;

    stat_t s_q, s_d;
    logic  clr;

    assign clr = ctl_wr_i && ctl_rst_stat_i;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.ovr  = 1'b0;
            s_d.perr = 1'b0;
            s_d.ferr = 1'b0;
        end
        if (rd_i) begin
            s_d.ready = 1'b0;
        end
        if (done_i) begin
            s_d.hold  = data_i;
            s_d.ready = 1'b1;
            if (s_q.ready && !rd_i) s_d.ovr  = 1'b1;
            if (par_bad_i)          s_d.perr = 1'b1;
            if (frm_bad_i)          s_d.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hold_o  = s_q.hold;
    assign ready_o = s_q.ready;
    assign ovr_o   = s_q.ovr;
    assign perr_o  = s_q.perr;
    assign ferr_o  = s_q.ferr;

    AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> ready_o); // R2
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && !done_i |=> !ready_o); // R4
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_i |=> $stable(hold_o)); // R4
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_o && !clr |=> ovr_o); // R6
    AST_NO_OVR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && rd_i && !ovr_o |=> !ovr_o && ready_o); // R9
    AST_FRAME_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && frm_bad_i |=> ferr_o && ready_o); // R8
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !done_i |=> !ovr_o && !perr_o && !ferr_o); // R10
endmodule

// File: rtl/sync_serial_rx.sv
module sync_serial_rx
    import sync_rx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_en,
    input  logic              rxd,
    input  logic [1:0]        par_mode,
    input  logic              rd_hold,
    input  logic              ctl_wr,
    input  logic              ctl_rst_stat,
    output logic [DATA_W-1:0] hold_data,
    output logic              rx_ready,
    output logic              ovr_err,
    output logic              par_err,
    output logic              frm_err
);
    logic              done_w;
    logic [DATA_W-1:0] data_w;
    logic              par_bad_w;
    logic              frm_bad_w;

    rx_frame_fsm #(.DATA_W(DATA_W)) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_en   (baud_en),
        .rxd       (rxd),
        .par_mode  (par_mode),
        .done_o    (done_w),
        .data_o    (data_w),
        .par_bad_o (par_bad_w),
        .frm_bad_o (frm_bad_w)
    );

    rx_hold_status #(.DATA_W(DATA_W)) status_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .done_i         (done_w),
        .data_i         (data_w),
        .par_bad_i      (par_bad_w),
        .frm_bad_i      (frm_bad_w),
        .rd_i           (rd_hold),
        .ctl_wr_i       (ctl_wr),
        .ctl_rst_stat_i (ctl_rst_stat),
        .hold_o         (hold_data),
        .ready_o        (rx_ready),
        .ovr_o          (ovr_err),
        .perr_o         (par_err),
        .ferr_o         (frm_err)
    );
endmodule

// File: tb/sync_serial_rx_tb_top.sv
module sync_serial_rx_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_en = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] par_mode = 2'd0;
    logic       rd_hold = 1'b0;
    logic       ctl_wr = 1'b0;
    logic       ctl_rst_stat = 1'b0;
    logic [7:0] hold_data;
    logic       rx_ready, ovr_err, par_err, frm_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sync_serial_rx #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .rxd(rxd),
        .par_mode(par_mode), .rd_hold(rd_hold), .ctl_wr(ctl_wr),
        .ctl_rst_stat(ctl_rst_stat), .hold_data(hold_data),
        .rx_ready(rx_ready), .ovr_err(ovr_err), .par_err(par_err),
        .frm_err(frm_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One enabled sample per bit; rxd is inverted on the idle cycle (R3)
    task automatic bit_tick(input logic b, input logic rd_after);
        @(negedge clk);
        baud_en = 1'b1;
        rxd     = b;
        @(negedge clk);
        baud_en = 1'b0;
        rxd     = ~b;
        rd_hold = rd_after;
    endtask

    task automatic send(input logic [7:0] d, input logic flip_par,
                        input logic stop_v, input logic rd_at_end);
        logic pb;
        pb = ((par_mode == 2'd2) ? ~^d : ^d) ^ flip_par;
        bit_tick(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) bit_tick(d[i], 1'b0);
        if (par_mode == 2'd1 || par_mode == 2'd2) bit_tick(pb, 1'b0);
        bit_tick(stop_v, rd_at_end);
        @(negedge clk);
        rd_hold = 1'b0;
        rxd     = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk); rd_hold = 1'b1;
        @(negedge clk); rd_hold = 1'b0;
    endtask

    task automatic ctl(input logic rs);
        @(negedge clk); ctl_wr = 1'b1; ctl_rst_stat = rs;
        @(negedge clk); ctl_wr = 1'b0; ctl_rst_stat = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 ready", rx_ready, 0);
        check("R1 flags", {ovr_err, par_err, frm_err}, 0);
        check("R1 hold", hold_data, 0);
    endtask

    task automatic t_basic();
        par_mode = 2'd0;
        send(8'hA5, 1'b0, 1'b1, 1'b0);
        check("R2 R3 hold A5", hold_data, 8'hA5);
        check("R2 ready", rx_ready, 1);
        check("R2 flags", {ovr_err, par_err, frm_err}, 0);
    endtask

    task automatic t_read();
        do_read();
        check("R4 ready cleared", rx_ready, 0);
        check("R4 hold kept", hold_data, 8'hA5);
        send(8'h3C, 1'b0, 1'b1, 1'b0);
        check("R2 hold 3C", hold_data, 8'h3C);
        do_read();
    endtask

    task automatic t_overrun();
        send(8'h11, 1'b0, 1'b1, 1'b0);
        check("R5 no ovr yet", ovr_err, 0);
        send(8'h22, 1'b0, 1'b1, 1'b0);
        check("R5 ovr set", ovr_err, 1);
        check("R5 newest kept", hold_data, 8'h22);
        do_read();
        check("R6 ovr after read", ovr_err, 1);
        ctl(1'b0);
        check("R6 ovr after plain ctl", ovr_err, 1);
        ctl(1'b1);
        check("R10 ovr cleared", ovr_err, 0);
    endtask

    task automatic t_parity();
        par_mode = 2'd1;
        send(8'h5A, 1'b0, 1'b1, 1'b0);
        check("R7 even good", par_err, 0);
        check("R7 even hold", hold_data, 8'h5A);
        do_read();
        send(8'h5B, 1'b1, 1'b1, 1'b0);
        check("R7 even bad", par_err, 1);
        do_read(); ctl(1'b1);
        par_mode = 2'd2;
        send(8'h07, 1'b0, 1'b1, 1'b0);
        check("R7 odd good", par_err, 0);
        check("R7 odd hold", hold_data, 8'h07);
        do_read();
        send(8'hE0, 1'b1, 1'b1, 1'b0);
        check("R7 odd bad", par_err, 1);
        do_read(); ctl(1'b1);
        par_mode = 2'd3;
        send(8'h81, 1'b0, 1'b1, 1'b0);
        check("R7 mode3 no parity hold", hold_data, 8'h81);
        check("R7 mode3 no perr", {par_err, frm_err}, 0);
        do_read();
    endtask

    task automatic t_frame();
        par_mode = 2'd1;
        send(8'hC3, 1'b1, 1'b0, 1'b0);
        check("R8 ferr", frm_err, 1);
        check("R8 hold", hold_data, 8'hC3);
        check("R8 ready", rx_ready, 1);
        check("R7 perr too", par_err, 1);
        ctl(1'b1);
        check("R10 all clear", {ovr_err, par_err, frm_err}, 0);
        check("R10 ready untouched", rx_ready, 1);
    endtask

    task automatic t_coincide();
        par_mode = 2'd0;
        send(8'h99, 1'b0, 1'b1, 1'b1);
        check("R9 ready kept", rx_ready, 1);
        check("R9 no ovr", ovr_err, 0);
        check("R9 hold", hold_data, 8'h99);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_read();
        t_overrun();
        t_parity();
        t_frame();
        t_coincide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule